// File: doc/BRIEF.md
# Interrupt Pin Latch and Dispatcher

This block sits between a bank of interrupt request wires and the message fabric that carries interrupts to processors. It watches every request pin, remembers which pins are asking for service in a pending register, and walks the pins in a fixed order. For every pin that is pending and not masked it builds one delivery message from that pin's routing entry. The routing entries come from a separate register block as a flat bus, together with a one-cycle pulse that marks any write to the table.

Messages leave one at a time on a valid/ready handshake. A pin can be programmed as edge-sensitive or level-sensitive. An edge pin is delivered once per rising edge. A level pin stays pending for as long as its wire is high, so every new walk over the pins sends it again. A walk starts when any pin shows a fresh rising edge or when the table is written. A walk that is asked for while one is already running is remembered and starts once the running walk ends.

Top module: `irq_pin_dispatch`

## Requirements
- R1: While `rst_n` is low and just after it rises, `msg_valid` is 0 and every pending bit is clear, so a pin event seen before reset produces no message after reset even when its entry is then unmasked.
- R2: Entry `i` occupies `route_tbl[i*23 +: 23]`, packed from most to least significant as destination (8 bits), mask (1 = masked), trigger (1 = level, 0 = edge), polarity, destination mode, delivery mode (3 bits), vector (8 bits).
- R3: On an edge pin, a rising edge of the input sets its pending bit, and a later fall of the input leaves the bit unchanged.
- R4: On a level pin, the pending bit follows the input: a high input sets it and a low input clears it.
- R5: A walk over the pins starts after any rising edge on any pin input and after any pulse on `route_wr`.
- R6: A walk visits pins in ascending index order from 0 to NPINS-1, and every pin that is pending and unmasked when visited produces exactly one message in that walk.
- R7: A masked pin produces no message and keeps its pending bit, so unmasking it later yields a message.
- R8: An accepted message from an edge pin clears that pin's pending bit; a level pin stays pending and is sent again on the next walk while its input is high.
- R9: The message carries the entry's destination, destination mode, delivery mode, vector, polarity and trigger fields unchanged.
- R10: When the delivery mode is 3'b111 (external interrupt) the message vector is 8'hFF whatever the entry's vector field holds.
- R11: While `msg_valid` is high and `msg_ready` is low the message fields and `msg_valid` hold steady, even across table writes; one message is consumed per cycle with both high.
- R12: A walk request that arrives while a walk is running is held and starts a fresh walk from pin 0 after the running one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pins | input | NPINS | Interrupt request wires, sampled each clock |
| route_tbl | input | NPINS*23 | Routing entries, packed as in R2 |
| route_wr | input | 1 | One-cycle pulse marking a write to the routing table |
| msg_valid | output | 1 | A delivery message is offered |
| msg_ready | input | 1 | The fabric takes the offered message |
| msg_dest | output | 8 | Destination field |
| msg_dest_mode | output | 1 | Destination mode field |
| msg_dlv_mode | output | 3 | Delivery mode field |
| msg_vector | output | 8 | Vector, or 8'hFF for external interrupt mode |
| msg_polarity | output | 1 | Polarity field |
| msg_trigger | output | 1 | Trigger field (1 = level) |

## Verification
The properties assume the pin wires and the routing bus are synchronous to `clk` and stable across each rising edge, and that `route_wr` is only ever a pulse accompanying a real change of the bus. They also rely on a routing entry not switching a pin between edge and level mode in the same cycle that pin's message is accepted, which the edge-clear property excludes explicitly. The stimulus changes pins, the table and `msg_ready` only on the falling clock edge, writes entries one at a time with a single-cycle `route_wr`, and only flips a pin's trigger mode while that pin is masked and idle.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

   // field widths of one routing entry
   localparam int DEST_W = 8;
   localparam int VEC_W  = 8;
   localparam int DLV_W  = 3;

   // delivery mode that replaces the vector
   localparam logic [DLV_W-1:0] DLV_EXTERNAL = 3'b111;
   localparam logic [VEC_W-1:0] VEC_EXTERNAL = 8'hFF;

   // one routing entry as presented by the register block (MSB first)
   typedef struct packed {
      logic [DEST_W-1:0] dest;
      logic              mask;
      logic              level;
      logic              pol;
      logic              dmode;
      logic [DLV_W-1:0]  dlv;
      logic [VEC_W-1:0]  vec;
   } route_ent_t;

   localparam int ENT_W = $bits(route_ent_t);

   // one outgoing delivery message
   typedef struct packed {
      logic [DEST_W-1:0] dest;
      logic              dmode;
      logic [DLV_W-1:0]  dlv;
      logic [VEC_W-1:0]  vec;
      logic              pol;
      logic              trig;
   } dmsg_t;

   localparam int MSG_W = $bits(dmsg_t);

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_HOLD = 2'd2
   } walk_st_e;

endpackage

// File: rtl/irqd_pin_sampler.sv
// Registers the request wires once per clock and flags fresh rising edges.
module irqd_pin_sampler #(
   parameter int NPINS = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pins_i,
   output logic [NPINS-1:0] rise_o
);

   logic [NPINS-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pins_i;
   end

   // a wire that is high now and was low on the previous edge
   assign rise_o = pins_i & ~prev_q;

endmodule

// File: rtl/irqd_pend_bank.sv
// Per-pin pending flags; each slice picks its update rule from the trigger mode.
module irqd_pend_bank #(
   parameter int NPINS = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pins_i,
   input  logic [NPINS-1:0] rise_i,
   input  logic [NPINS-1:0] level_i,
   input  logic [NPINS-1:0] clr_i,
   output logic [NPINS-1:0] pend_o
);

   for (genvar g = 0; g < NPINS; g++) begin : g_slot
      logic pend_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
         end else if (level_i[g]) begin
            // level pin: pending mirrors the wire, delivery does not clear it
            pend_q <= pins_i[g];
         end else if (rise_i[g]) begin
            // a new edge wins over a delivery clear in the same cycle
            pend_q <= 1'b1;
         end else if (clr_i[g]) begin
            pend_q <= 1'b0;
         end
      end

      assign pend_o[g] = pend_q;
   end

endmodule

// File: rtl/irqd_msg_build.sv
// Turns one routing entry into the delivery message it would produce.
module irqd_msg_build
   import irqd_pkg::*;
(
   input  route_ent_t ent_i,
   output dmsg_t      msg_o
);

   always_comb begin
      msg_o.dest  = ent_i.dest;
      msg_o.dmode = ent_i.dmode;
      msg_o.dlv   = ent_i.dlv;
      msg_o.pol   = ent_i.pol;
      msg_o.trig  = ent_i.level;
      msg_o.vec   = (ent_i.dlv == DLV_EXTERNAL) ? VEC_EXTERNAL : ent_i.vec;
   end

endmodule

// File: rtl/irqd_walk_ctl.sv
// Walks the pins in ascending order, one index per cycle, pausing on each hit
// until the fabric accepts the message. Requests during a walk are held.
module irqd_walk_ctl
   import irqd_pkg::*;
#(
   parameter int NPINS = 24,
   parameter int IDX_W = $clog2(NPINS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kick_i,
   input  logic [NPINS-1:0] pend_i,
   input  logic [NPINS-1:0] mask_i,
   input  logic             ready_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             load_o,
   output logic             deliver_o,
   output logic             valid_o,
   output logic             busy_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPINS - 1);

   walk_st_e         st_q;
   logic [IDX_W-1:0] idx_q;
   logic             rescan_q;
   logic             hit;
   logic             last;
   logic             advance;
   logic             wrap;
   logic             again;

   always_comb begin
      hit     = pend_i[idx_q] & ~mask_i[idx_q];
      last    = (idx_q == LAST_IDX);
      advance = ((st_q == ST_SCAN) && !hit) || ((st_q == ST_HOLD) && ready_i);
      wrap    = advance && last;
      again   = rescan_q || kick_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         idx_q    <= '0;
         rescan_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (kick_i) begin
                  st_q  <= ST_SCAN;
                  idx_q <= '0;
               end
            end
            ST_SCAN: begin
               if (hit) begin
                  st_q <= ST_HOLD;
               end else if (last) begin
                  if (again) idx_q <= '0;
                  else       st_q  <= ST_IDLE;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_HOLD: begin
               if (ready_i) begin
                  if (last) begin
                     if (again) begin
                        st_q  <= ST_SCAN;
                        idx_q <= '0;
                     end else begin
                        st_q <= ST_IDLE;
                     end
                  end else begin
                     st_q  <= ST_SCAN;
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase

         // a walk request seen mid-walk is kept until the walk wraps
         if (wrap)                            rescan_q <= 1'b0;
         else if (kick_i && st_q != ST_IDLE)  rescan_q <= 1'b1;
      end
   end

   assign idx_o     = idx_q;
   assign load_o    = (st_q == ST_SCAN) && hit;
   assign deliver_o = (st_q == ST_HOLD) && ready_i;
   assign valid_o   = (st_q == ST_HOLD);
   assign busy_o    = (st_q != ST_IDLE);

endmodule

// File: rtl/irq_pin_dispatch.sv
// Top: pin sampling, pending flags, ordered walk and the message register.
module irq_pin_dispatch
   import irqd_pkg::*;
#(
   parameter int NPINS = 24,
   parameter int IDX_W = $clog2(NPINS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPINS-1:0]       irq_pins,
   input  logic [NPINS*ENT_W-1:0] route_tbl,
   input  logic                   route_wr,
   output logic                   msg_valid,
   input  logic                   msg_ready,
   output logic [DEST_W-1:0]      msg_dest,
   output logic                   msg_dest_mode,
   output logic [DLV_W-1:0]       msg_dlv_mode,
   output logic [VEC_W-1:0]       msg_vector,
   output logic                   msg_polarity,
   output logic                   msg_trigger
);

   // elaboration checks on the parameter set
   if (NPINS < 2 || NPINS > 64) begin : g_bad_npins
      $error("irq_pin_dispatch: NPINS must lie in 2..64");
   end
   if ((1 << IDX_W) < NPINS) begin : g_bad_idx
      $error("irq_pin_dispatch: IDX_W too narrow for NPINS");
   end

   route_ent_t       ent_arr [NPINS];
   logic [NPINS-1:0] level_vec;
   logic [NPINS-1:0] mask_vec;
   logic [NPINS-1:0] rise_vec;
   logic [NPINS-1:0] pend_vec;
   logic [NPINS-1:0] clr_vec;
   logic [IDX_W-1:0] cur_idx;
   logic             walk_load;
   logic             walk_deliver;
   logic             walk_valid;
   logic             walk_busy;
   logic             kick;
   dmsg_t            next_msg;
   dmsg_t            msg_q;

   // unpack the routing bus into entries and per-pin mode vectors
   for (genvar g = 0; g < NPINS; g++) begin : g_ent
      assign ent_arr[g]   = route_ent_t'(route_tbl[g*ENT_W +: ENT_W]);
      assign level_vec[g] = ent_arr[g].level;
      assign mask_vec[g]  = ent_arr[g].mask;
      // only an accepted edge-mode message clears its own pin
      assign clr_vec[g]   = walk_deliver && !msg_q.trig && (cur_idx == IDX_W'(g));
   end

   irqd_pin_sampler #(.NPINS(NPINS)) u_samp (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins_i (irq_pins),
      .rise_o (rise_vec)
   );

   irqd_pend_bank #(.NPINS(NPINS)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins_i  (irq_pins),
      .rise_i  (rise_vec),
      .level_i (level_vec),
      .clr_i   (clr_vec),
      .pend_o  (pend_vec)
   );

   assign kick = (|rise_vec) || route_wr;

   irqd_walk_ctl #(.NPINS(NPINS), .IDX_W(IDX_W)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .kick_i    (kick),
      .pend_i    (pend_vec),
      .mask_i    (mask_vec),
      .ready_i   (msg_ready),
      .idx_o     (cur_idx),
      .load_o    (walk_load),
      .deliver_o (walk_deliver),
      .valid_o   (walk_valid),
      .busy_o    (walk_busy)
   );

   irqd_msg_build u_build (
      .ent_i (ent_arr[cur_idx]),
      .msg_o (next_msg)
   );

   // the offered message is frozen from load until acceptance
   always_ff @(posedge clk) begin
      if (!rst_n)         msg_q <= '0;
      else if (walk_load) msg_q <= next_msg;
   end

   assign msg_valid     = walk_valid;
   assign msg_dest      = msg_q.dest;
   assign msg_dest_mode = msg_q.dmode;
   assign msg_dlv_mode  = msg_q.dlv;
   assign msg_vector    = msg_q.vec;
   assign msg_polarity  = msg_q.pol;
   assign msg_trigger   = msg_q.trig;

endmodule

// File: rtl/irqd_checker.sv
// Temporal properties for irq_pin_dispatch, attached through bind below.
module irqd_checker
   import irqd_pkg::*;
#(
   parameter int NPINS = 24,
   parameter int IDX_W = $clog2(NPINS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPINS-1:0] pins,
   input logic [NPINS-1:0] rise,
   input logic [NPINS-1:0] pend,
   input logic [NPINS-1:0] mask,
   input logic [NPINS-1:0] level,
   input logic [IDX_W-1:0] idx,
   input logic             valid,
   input logic             ready,
   input logic [MSG_W-1:0] msg_bus
);

   logic [NPINS-1:0] eligible;
   dmsg_t            m;

   assign eligible = pend & ~mask;
   assign m        = dmsg_t'(msg_bus);

   // backpressure freezes the offer
   assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(msg_bus)));

   // external interrupt mode never carries the table vector
   assert_ext_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && m.dlv == DLV_EXTERNAL) |-> (m.vec == VEC_EXTERNAL));

   // an offer only starts for a pin that was pending and unmasked
   assert_offer_eligible_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> $past(eligible[idx]));

   // a low level-mode wire leaves no pending bit behind
   assert_level_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & $past(level & ~pins)) == '0));

   // an accepted edge-mode offer clears its pin unless a new edge came at once
   assert_edge_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready && !m.trig && !rise[idx] && !level[idx]) |=> !pend[$past(idx)]);

endmodule

bind irq_pin_dispatch irqd_checker #(.NPINS(NPINS), .IDX_W(IDX_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pins    (irq_pins),
   .rise    (rise_vec),
   .pend    (pend_vec),
   .mask    (mask_vec),
   .level   (level_vec),
   .idx     (cur_idx),
   .valid   (msg_valid),
   .ready   (msg_ready),
   .msg_bus (msg_q)
);

// File: tb/sim_irq_pin_dispatch.sv
`timescale 1ns/1ps
module sim_irq_pin_dispatch;

   localparam int NP   = 24;
   localparam int EW   = 23;
   localparam int WAIT = 80;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NP-1:0]    irq_pins = '0;
   logic [NP*EW-1:0] route_tbl;
   logic             route_wr = 1'b0;
   logic             msg_valid;
   logic             msg_ready = 1'b0;
   logic [7:0]       msg_dest;
   logic             msg_dest_mode;
   logic [2:0]       msg_dlv_mode;
   logic [7:0]       msg_vector;
   logic             msg_polarity;
   logic             msg_trigger;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   irq_pin_dispatch u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .irq_pins      (irq_pins),
      .route_tbl     (route_tbl),
      .route_wr      (route_wr),
      .msg_valid     (msg_valid),
      .msg_ready     (msg_ready),
      .msg_dest      (msg_dest),
      .msg_dest_mode (msg_dest_mode),
      .msg_dlv_mode  (msg_dlv_mode),
      .msg_vector    (msg_vector),
      .msg_polarity  (msg_polarity),
      .msg_trigger   (msg_trigger)
   );

   // row: pin(5) level mask pol dmode dlv(3) vec(8) dest(8)
   localparam logic [27:0] ROWS [0:7] = '{
      {5'd3,  1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h31, 8'h05},
      {5'd0,  1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 8'h40, 8'h81},
      {5'd23, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h55, 8'hFE},
      {5'd7,  1'b0, 1'b0, 1'b0, 1'b1, 3'd7, 8'h22, 8'h10},
      {5'd9,  1'b1, 1'b0, 1'b1, 1'b0, 3'd4, 8'h66, 8'h11},
      {5'd12, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'h77, 8'h02},
      {5'd15, 1'b1, 1'b1, 1'b1, 1'b1, 3'd5, 8'h88, 8'h03},
      {5'd1,  1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 8'h99, 8'h44}
   };

   // R2 packing: dest, mask, level, pol, dmode, dlv, vec
   function automatic logic [EW-1:0] mk_ent(input logic [7:0] dest, input logic mask,
         input logic lvl, input logic pol, input logic dmode,
         input logic [2:0] dlv, input logic [7:0] vec);
      return {dest, mask, lvl, pol, dmode, dlv, vec};
   endfunction

   function automatic logic [21:0] exp_msg(input logic [7:0] dest, input logic lvl,
         input logic pol, input logic dmode, input logic [2:0] dlv, input logic [7:0] vec);
      return {dest, dmode, dlv, (dlv == 3'd7) ? 8'hFF : vec, pol, lvl};
   endfunction

   function automatic logic [21:0] got_msg();
      return {msg_dest, msg_dest_mode, msg_dlv_mode, msg_vector, msg_polarity, msg_trigger};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] got,
         input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic set_ent(input int pin, input logic [EW-1:0] ent);
      @(negedge clk);
      route_tbl[pin*EW +: EW] = ent;
      route_wr = 1'b1;
      @(negedge clk);
      route_wr = 1'b0;
   endtask

   task automatic wait_msg(output bit seen);
      for (int c = 0; c < WAIT && !msg_valid; c++) @(negedge clk);
      seen = msg_valid;
   endtask

   task automatic quiet(output bit seen);
      seen = 1'b0;
      for (int c = 0; c < WAIT; c++) begin
         @(negedge clk);
         if (msg_valid) seen = 1'b1;
      end
   endtask

   task automatic ack();
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
   endtask

   task automatic pulse(input int pin);
      @(negedge clk);
      irq_pins[pin] = 1'b1;
      @(negedge clk);
      irq_pins[pin] = 1'b0;
   endtask

   task automatic mask_all();
      for (int p = 0; p < NP; p++)
         route_tbl[p*EW +: EW] = mk_ent(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00);
   endtask

   // watchdog: an expired run is one failed check and still prints the summary
   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      bit seen;
      logic [21:0] snap;
      mask_all();
      repeat (3) @(negedge clk);
      check(msg_valid == 1'b0, "R1 valid low in reset", 32'(msg_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(msg_valid == 1'b0, "R1 valid low after reset", 32'(msg_valid), 0);

      // ---------- table walk ----------
      for (int r = 0; r < 8; r++) begin
         logic [27:0] row;
         int pin;
         logic lvl, msk, pol, dm;
         logic [2:0] dlv;
         logic [7:0] vec, dest;
         row  = ROWS[r];
         pin  = int'(row[27:23]);
         lvl  = row[22]; msk = row[21]; pol = row[20]; dm = row[19];
         dlv  = row[18:16]; vec = row[15:8]; dest = row[7:0];

         set_ent(pin, mk_ent(dest, msk, lvl, pol, dm, dlv, vec));
         quiet(seen);
         @(negedge clk);
         irq_pins[pin] = 1'b1;
         if (!lvl) begin
            @(negedge clk);
            irq_pins[pin] = 1'b0;
         end
         if (msk) begin
            quiet(seen);
            check(!seen, "R7 masked pin sends nothing", 32'(seen), 0);
            set_ent(pin, mk_ent(dest, 1'b0, lvl, pol, dm, dlv, vec));
         end
         wait_msg(seen);
         check(seen, lvl ? "R4 level pin offered" : "R3 edge pin offered", 32'(seen), 1);
         check(got_msg() == exp_msg(dest, lvl, pol, dm, dlv, vec),
               (dlv == 3'd7) ? "R10 external vector" : "R9 message fields",
               32'(got_msg()), 32'(exp_msg(dest, lvl, pol, dm, dlv, vec)));
         check(msg_trigger == lvl, "R2 trigger decode", 32'(msg_trigger), 32'(lvl));
         ack();
         @(negedge clk);
         irq_pins[pin] = 1'b0;
         set_ent(pin, mk_ent(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00));
         quiet(seen);
      end

      // ---------- R6 ascending order ----------
      set_ent(20, mk_ent(8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'hA0));
      set_ent(4,  mk_ent(8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'hA4));
      set_ent(2,  mk_ent(8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'hA2));
      quiet(seen);
      @(negedge clk);
      irq_pins[20] = 1'b1; irq_pins[4] = 1'b1; irq_pins[2] = 1'b1;
      @(negedge clk);
      irq_pins = '0;
      wait_msg(seen);
      check(seen && msg_vector == 8'hA2, "R6 first pin 2", 32'(msg_vector), 32'hA2);
      ack();
      wait_msg(seen);
      check(seen && msg_vector == 8'hA4, "R6 second pin 4", 32'(msg_vector), 32'hA4);
      ack();
      wait_msg(seen);
      check(seen && msg_vector == 8'hA0, "R6 third pin 20", 32'(msg_vector), 32'hA0);
      ack();
      quiet(seen);
      check(!seen, "R6 one message per pin", 32'(seen), 0);

      // ---------- R11 hold under backpressure, R8 edge clear ----------
      set_ent(6, mk_ent(8'h06, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h60));
      quiet(seen);
      pulse(6);
      wait_msg(seen);
      snap = got_msg();
      set_ent(6, mk_ent(8'h07, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 8'h61));
      repeat (4) @(negedge clk);
      check(msg_valid && got_msg() == snap, "R11 offer held", 32'(got_msg()), 32'(snap));
      ack();
      quiet(seen);
      check(!seen, "R8 edge pin cleared after delivery", 32'(seen), 0);
      set_ent(6, mk_ent(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00));

      // ---------- R12 request held during a walk ----------
      set_ent(5, mk_ent(8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'hB5));
      set_ent(3, mk_ent(8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'hB3));
      quiet(seen);
      pulse(5);
      wait_msg(seen);
      check(seen && msg_vector == 8'hB5, "R12 first offer pin 5", 32'(msg_vector), 32'hB5);
      pulse(3);
      check(msg_valid && msg_vector == 8'hB5, "R12 pin 5 still offered", 32'(msg_vector), 32'hB5);
      ack();
      wait_msg(seen);
      check(seen && msg_vector == 8'hB3, "R12 rescan finds pin 3", 32'(msg_vector), 32'hB3);
      ack();
      quiet(seen);
      set_ent(5, mk_ent(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00));
      set_ent(3, mk_ent(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00));

      // ---------- R8 level resend, R5 write kick, R4 deassert clear ----------
      set_ent(10, mk_ent(8'h0A, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'hCA));
      quiet(seen);
      @(negedge clk);
      irq_pins[10] = 1'b1;
      wait_msg(seen);
      check(seen && msg_vector == 8'hCA, "R4 level offer", 32'(msg_vector), 32'hCA);
      ack();
      quiet(seen);
      check(!seen, "R5 no walk without a request", 32'(seen), 0);
      set_ent(11, mk_ent(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00));
      wait_msg(seen);
      check(seen && msg_vector == 8'hCA, "R8 level pin sent again on R5 write", 32'(seen), 1);
      ack();
      quiet(seen);
      @(negedge clk);
      irq_pins[10] = 1'b0;
      @(negedge clk);
      set_ent(11, mk_ent(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00));
      quiet(seen);
      check(!seen, "R4 low wire clears pending", 32'(seen), 0);
      set_ent(10, mk_ent(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00));

      // ---------- R1 reset drops pending ----------
      set_ent(13, mk_ent(8'h0D, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'hDD));
      pulse(13);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check(msg_valid == 1'b0, "R1 valid low after mid-run reset", 32'(msg_valid), 0);
      set_ent(13, mk_ent(8'h0D, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'hDD));
      quiet(seen);
      check(!seen, "R1 pending cleared by reset", 32'(seen), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule